// File: doc/BRIEF.md
# Nonvolatile Program Memory Program/Erase Controller

This block fronts a 1 KB program store (four sectors of 256 bytes, each cut into 16-byte pages). The store is held inside the block as a register array. A CPU-side command port takes one command per cycle. The commands fill a 16-byte page staging buffer, program a page from that buffer, erase at byte, page, sector or whole-array granularity, and lock a sector against changes. A separate read port returns array bytes.

Programming can only clear bits: each staged byte is ANDed into the byte already stored. Erase drives bytes to 0xFF. Every timed operation runs for one fixed window of `OP_CYCLES` clocks, which by default is 2 ms at the stated clock rate. While the window runs, the block sets `busy` and refuses new commands. It marks the end of the window with a single-cycle `done`. Inside the window a sequencer walks the affected addresses one per clock, so the array keeps a single write port.

Top module: `flash_pe_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `busy_err`, `prot_err` and `rd_valid` are all low, and no sector is locked.
- R2: Command code 0 (load), accepted while idle, stores `cmd_data` in staging slot `cmd_addr[3:0]` and marks that slot; the array is unchanged.
- R3: Command code 1 (program) updates the page `cmd_addr[9:4]`. Each marked slot i sets the byte at page*16+i to its old value AND the slot's data. Unmarked bytes of that page keep their value.
- R4: All slot marks clear when a program operation completes, and also when a program command is refused for a locked sector. A later program with nothing loaded changes nothing.
- R5: Command code 2 (byte erase) sets the byte at `cmd_addr` to 0xFF and leaves every other byte unchanged.
- R6: Command code 3 (page erase) sets the 16 bytes of page `cmd_addr[9:4]` to 0xFF.
- R7: Command code 4 (sector erase) sets the 256 bytes of sector `cmd_addr[9:8]` to 0xFF and leaves other sectors unchanged.
- R8: Command code 5 (chip erase) sets every byte to 0xFF regardless of locks, and clears all sector locks when it completes.
- R9: A timed command (codes 1 to 5) accepted at a clock edge raises `busy` from that edge for exactly max(`OP_CYCLES`, 1028) cycles. `done` is high for one cycle, in the first cycle that `busy` is low again.
- R10: A command presented while `busy` is high has no effect and sets `busy_err`. The next command accepted while idle (codes 0 to 6) clears `busy_err` and `prot_err`.
- R11: Command code 6 (lock) locks sector `cmd_addr[9:8]` at once. A program or byte/page/sector erase aimed at a locked sector leaves the array unchanged, does not raise `busy`, and sets `prot_err`.
- R12: `rd_en` at a clock edge gives `rd_valid` high in the next cycle. `rd_data` then holds the byte at `rd_addr` if `busy` was low when `rd_en` was sampled, and 0xFF if `busy` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 load, 1 program, 2 byte erase, 3 page erase, 4 sector erase, 5 chip erase, 6 lock, 7 ignored) |
| cmd_addr | input | 10 | Target byte address; low bits pick the staging slot for load |
| cmd_data | input | 8 | Byte to stage for load |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 10 | Read byte address |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | Timed operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| busy_err | output | 1 | A command arrived while busy |
| prot_err | output | 1 | Last accepted command hit a locked sector |

## Verification
The bench builds the block with its default geometry and sets `OP_CYCLES` to 1100. At that value the timing window is set by the parameter and is not clamped by the walk length, so exact window length, chip erase and locking can all be exercised in a few tens of thousands of cycles. A vector table covers the full path of staging, AND-programming, the four erase sizes and locking. Directed tests then cover window length, blanked reads while busy, refused commands, and mark clearing after a completed program and after a refused one.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_PROG = 3'd1,
    OP_ERB  = 3'd2,
    OP_ERP  = 3'd3,
    OP_ERS  = 3'd4,
    OP_ERC  = 3'd5,
    OP_LOCK = 3'd6,
    OP_RSVD = 3'd7
  } fop_e;
endpackage

// File: rtl/fpe_array.sv
// Byte array with one synchronous read port and one write port (block RAM shape).
module fpe_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
    if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fpe_pagebuf.sv
// Staging buffer: one data byte and one mark bit per page slot.
module fpe_pagebuf #(
  parameter int PAGE_BYTES = 16,
  parameter int PW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [PW-1:0] ld_idx,
  input  logic [7:0]    ld_data,
  input  logic          clr,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic          rd_keep
);
  logic [7:0] slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] keep_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ld_en && ld_idx == PW'(g)) slot_q[g] <= ld_data;
    end
    always_ff @(posedge clk) begin
      if (rst)                            keep_q[g] <= 1'b0;
      else if (ld_en && ld_idx == PW'(g)) keep_q[g] <= 1'b1;
      else if (clr)                       keep_q[g] <= 1'b0;
    end
  end

  assign rd_byte = slot_q[rd_idx];
  assign rd_keep = keep_q[rd_idx];
endmodule

// File: rtl/fpe_lock.sv
// Per-sector lock bits.
module fpe_lock #(
  parameter int SECTORS = 4,
  parameter int SECW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [SECW-1:0]    set_idx,
  input  logic               clr_all,
  input  logic [SECW-1:0]    chk_idx,
  output logic               chk_locked
);
  logic [SECTORS-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else begin
      if (clr_all) lock_q <= '0;
      if (set_en)  lock_q[set_idx] <= 1'b1;
    end
  end

  assign chk_locked = lock_q[chk_idx];
endmodule

// File: rtl/fpe_seq.sv
// Fixed-length operation timer plus an address walker with a one-stage write pipe.
module fpe_seq #(
  parameter int AW     = 10,
  parameter int OP_LEN = 1028,
  parameter int CW     = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  output logic          busy,
  output logic          done,
  output logic          iss_vld,
  output logic [AW-1:0] iss_addr,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr
);
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] idx_q, last_q, s_addr_q;
  logic          walk_q, s_vld_q, busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      walk_q   <= 1'b0;
      s_vld_q  <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      s_addr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      s_vld_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        idx_q  <= lo_addr;
        last_q <= hi_addr;
        walk_q <= 1'b1;
      end else if (busy_q) begin
        if (walk_q) begin
          s_vld_q  <= 1'b1;
          s_addr_q <= idx_q;
          if (idx_q == last_q) walk_q <= 1'b0;
          else                 idx_q  <= idx_q + 1'b1;
        end
        if (cnt_q == CW'(OP_LEN - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign iss_vld  = busy_q && walk_q;
  assign iss_addr = idx_q;
  assign wr_vld   = s_vld_q;
  assign wr_addr  = s_addr_q;
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int CLK_HZ       = 18_000_000,
  parameter int OP_CYCLES    = CLK_HZ / 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0] cmd_addr,
  input  logic [7:0] cmd_data,
  input  logic       rd_en,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       busy,
  output logic       done,
  output logic       busy_err,
  output logic       prot_err
);
  localparam int MEM_BYTES = SECTORS * SECTOR_BYTES;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PW        = $clog2(PAGE_BYTES);
  localparam int SW        = $clog2(SECTOR_BYTES);
  localparam int SECW      = AW - SW;
  localparam int OP_LEN    = (OP_CYCLES < MEM_BYTES + 4) ? MEM_BYTES + 4 : OP_CYCLES;
  localparam int CW        = $clog2(OP_LEN);

  fop_e          op, cur_op_q;
  logic          accept, timed, guarded, locked, viol, start;
  logic [AW-1:0] lo_addr, hi_addr;
  logic          iss_vld, wr_vld;
  logic [AW-1:0] iss_addr, wr_addr;
  logic [7:0]    arr_q, buf_byte, wdata;
  logic          buf_keep, wen, busy_err_q, prot_err_q, rd_valid_q, rd_blank_q;

  assign op      = fop_e'(cmd_op);
  assign accept  = cmd_valid && !busy;
  assign timed   = (op == OP_PROG) || (op == OP_ERB) || (op == OP_ERP) ||
                   (op == OP_ERS)  || (op == OP_ERC);
  assign guarded = timed && (op != OP_ERC);
  assign viol    = accept && guarded && locked;
  assign start   = accept && timed && !viol;

  always_comb begin
    unique case (op)
      OP_PROG, OP_ERP: begin
        lo_addr = {cmd_addr[AW-1:PW], {PW{1'b0}}};
        hi_addr = {cmd_addr[AW-1:PW], {PW{1'b1}}};
      end
      OP_ERB: begin
        lo_addr = cmd_addr;
        hi_addr = cmd_addr;
      end
      OP_ERS: begin
        lo_addr = {cmd_addr[AW-1:SW], {SW{1'b0}}};
        hi_addr = {cmd_addr[AW-1:SW], {SW{1'b1}}};
      end
      default: begin
        lo_addr = '0;
        hi_addr = '1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        cur_op_q <= OP_LOAD;
    else if (start) cur_op_q <= op;
  end

  fpe_seq #(.AW(AW), .OP_LEN(OP_LEN), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .lo_addr(lo_addr), .hi_addr(hi_addr),
    .busy(busy), .done(done), .iss_vld(iss_vld), .iss_addr(iss_addr),
    .wr_vld(wr_vld), .wr_addr(wr_addr)
  );

  fpe_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_buf (
    .clk(clk), .rst(rst),
    .ld_en(accept && op == OP_LOAD), .ld_idx(cmd_addr[PW-1:0]), .ld_data(cmd_data),
    .clr((done && cur_op_q == OP_PROG) || (viol && op == OP_PROG)),
    .rd_idx(wr_addr[PW-1:0]), .rd_byte(buf_byte), .rd_keep(buf_keep)
  );

  fpe_lock #(.SECTORS(SECTORS), .SECW(SECW)) u_lock (
    .clk(clk), .rst(rst),
    .set_en(accept && op == OP_LOCK), .set_idx(cmd_addr[AW-1:SW]),
    .clr_all(done && cur_op_q == OP_ERC),
    .chk_idx(cmd_addr[AW-1:SW]), .chk_locked(locked)
  );

  // program ANDs staged data into the old byte; every erase writes all ones
  assign wdata = (cur_op_q == OP_PROG) ? (arr_q & buf_byte) : 8'hFF;
  assign wen   = wr_vld && ((cur_op_q != OP_PROG) || buf_keep);

  fpe_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_arr (
    .clk(clk),
    .ren(busy ? iss_vld : rd_en), .raddr(busy ? iss_addr : rd_addr), .rdata(arr_q),
    .wen(wen), .waddr(wr_addr), .wdata(wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_err_q <= 1'b0;
      prot_err_q <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_blank_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_blank_q <= busy;
      if (cmd_valid && busy) begin
        busy_err_q <= 1'b1;
      end else if (accept && op != OP_RSVD) begin
        busy_err_q <= 1'b0;
        prot_err_q <= viol;
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_blank_q ? 8'hFF : arr_q;
  assign busy_err = busy_err_q;
  assign prot_err = prot_err_q;
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int OP_LEN = 1028
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       busy,
  input logic       done,
  input logic       busy_err,
  input logic       prot_err,
  input logic       rd_valid,
  input logic [7:0] rd_data
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < OP_LEN));

  // R10
  busy_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_err) |-> $past(cmd_valid && busy));

  // R11
  prot_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_err) |-> !busy);

  // R12
  rd_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(busy)) |-> (rd_data == 8'hFF));
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.OP_LEN(OP_LEN)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .busy_err(busy_err), .prot_err(prot_err), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/flash_pe_ctrl_tb.sv
`timescale 1ns/1ps
module flash_pe_ctrl_tb;
  localparam int OPC = 1100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [9:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       rd_en = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid, busy, done, busy_err, prot_err;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  flash_pe_ctrl #(.OP_CYCLES(OPC)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .busy_err(busy_err), .prot_err(prot_err)
  );

  // {req[3:0], op[2:0], addr[9:0], data[7:0], timed, chk_addr[9:0], exp[7:0]}; op 7 = no command
  localparam int NV = 22;
  localparam logic [43:0] VEC [NV] = '{
    {4'd8,  3'd5, 10'h000, 8'h00, 1'b1, 10'h3FF, 8'hFF}, // R8 chip erase
    {4'd2,  3'd0, 10'h003, 8'hA5, 1'b0, 10'h003, 8'hFF}, // R2 load leaves array
    {4'd2,  3'd0, 10'h005, 8'h0F, 1'b0, 10'h005, 8'hFF}, // R2
    {4'd3,  3'd1, 10'h120, 8'h00, 1'b1, 10'h123, 8'hA5}, // R3 program page 0x12
    {4'd3,  3'd7, 10'h000, 8'h00, 1'b0, 10'h125, 8'h0F}, // R3
    {4'd3,  3'd7, 10'h000, 8'h00, 1'b0, 10'h124, 8'hFF}, // R3 unmarked slot
    {4'd2,  3'd0, 10'h003, 8'h3C, 1'b0, 10'h123, 8'hA5}, // R2
    {4'd3,  3'd1, 10'h12F, 8'h00, 1'b1, 10'h123, 8'h24}, // R3 AND with old
    {4'd5,  3'd2, 10'h123, 8'h00, 1'b1, 10'h123, 8'hFF}, // R5 byte erase
    {4'd5,  3'd7, 10'h000, 8'h00, 1'b0, 10'h125, 8'h0F}, // R5 neighbour kept
    {4'd6,  3'd3, 10'h12A, 8'h00, 1'b1, 10'h125, 8'hFF}, // R6 page erase
    {4'd2,  3'd0, 10'h000, 8'h11, 1'b0, 10'h2F0, 8'hFF}, // R2
    {4'd3,  3'd1, 10'h2F0, 8'h00, 1'b1, 10'h2F0, 8'h11}, // R3
    {4'd2,  3'd0, 10'h00F, 8'h22, 1'b0, 10'h300, 8'hFF}, // R2
    {4'd3,  3'd1, 10'h300, 8'h00, 1'b1, 10'h30F, 8'h22}, // R3
    {4'd7,  3'd4, 10'h2FF, 8'h00, 1'b1, 10'h2F0, 8'hFF}, // R7 sector 2 erase
    {4'd7,  3'd7, 10'h000, 8'h00, 1'b0, 10'h30F, 8'h22}, // R7 sector 3 kept
    {4'd11, 3'd6, 10'h300, 8'h00, 1'b0, 10'h30F, 8'h22}, // R11 lock sector 3
    {4'd11, 3'd4, 10'h3AB, 8'h00, 1'b0, 10'h30F, 8'h22}, // R11 locked erase refused
    {4'd8,  3'd5, 10'h000, 8'h00, 1'b1, 10'h30F, 8'hFF}, // R8 chip erase ignores lock
    {4'd2,  3'd0, 10'h000, 8'h00, 1'b0, 10'h300, 8'hFF}, // R2
    {4'd8,  3'd1, 10'h300, 8'h00, 1'b1, 10'h300, 8'h00}  // R8 lock cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [9:0] addr, input logic [7:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, done}, 32'd1);
  endtask

  task automatic rd(input logic [9:0] addr, output logic [7:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", {27'd0, busy, done, busy_err, prot_err, rd_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {27'd0, busy, done, busy_err, prot_err, rd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d", e[43:40]);
      if (e[39:37] != 3'd7) begin
        send(e[39:37], e[36:27], e[26:19]);
        if (e[18]) wait_done(tag);
      end
      rd(e[17:8], v);
      check(tag, {24'd0, v}, {24'd0, e[7:0]});
    end

    // R9 window length and done pulse
    send(3'd2, 10'h010, 8'h00);
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
    check("R9 busy cycles", cnt, OPC);
    check("R9 done", {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R9 done width", {31'd0, done}, 32'd0);

    // R12 read while busy returns 0xFF; R10 refused load while busy
    send(3'd3, 10'h300, 8'h00);
    rd(10'h300, v);
    check("R12 valid", {31'd0, rd_valid}, 32'd1);
    check("R12 blank", {24'd0, v}, 32'h0000_00FF);
    send(3'd0, 10'h000, 8'h00);
    check("R10 busy_err", {31'd0, busy_err}, 32'd1);
    wait_done("R6");
    rd(10'h300, v);
    check("R6", {24'd0, v}, 32'h0000_00FF);
    send(3'd1, 10'h000, 8'h00);
    check("R10 cleared", {31'd0, busy_err}, 32'd0);
    wait_done("R10");
    rd(10'h000, v);
    check("R10 no effect", {24'd0, v}, 32'h0000_00FF);

    // R4 marks clear after a completed program
    send(3'd0, 10'h005, 8'h5A);
    send(3'd1, 10'h040, 8'h00);
    wait_done("R4");
    rd(10'h045, v);
    check("R3", {24'd0, v}, 32'h0000_005A);
    send(3'd3, 10'h040, 8'h00);
    wait_done("R6");
    send(3'd1, 10'h040, 8'h00);
    wait_done("R4");
    rd(10'h045, v);
    check("R4", {24'd0, v}, 32'h0000_00FF);

    // R11 locked program refused, marks cleared (R4)
    send(3'd6, 10'h100, 8'h00);
    send(3'd0, 10'h002, 8'h00);
    send(3'd1, 10'h100, 8'h00);
    check("R11 no busy", {31'd0, busy}, 32'd0);
    check("R11 prot_err", {31'd0, prot_err}, 32'd1);
    rd(10'h102, v);
    check("R11 array", {24'd0, v}, 32'h0000_00FF);
    send(3'd1, 10'h200, 8'h00);
    check("R10 prot cleared", {31'd0, prot_err}, 32'd0);
    wait_done("R4");
    rd(10'h202, v);
    check("R4 violation clear", {24'd0, v}, 32'h0000_00FF);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule